// File: doc/BRIEF.md
# Audio Transmit FIFO with Fill-Level Interrupts

This block sits between a processor's register bus and an audio serializer on a playback path. Software writes 32-bit sample words into a transmit queue, one word per channel slot. The serializer drains the queue through a pop port. The block also holds the playback configuration and brings its fields out to the serializer.

Two conditions are watched all the time: the queue is empty, and the queue fill is below a programmable low-water mark. Each condition latches a status bit. Software acknowledges a bit by writing 1 to it. One interrupt line is raised when the global interrupt enable is set and a latched cause is not masked.

The low-water mark is coded as a small exponent. Code 1 places it at half the queue depth, and each further step halves it. Software uses the interrupt to refill the queue before it runs dry.

Top module: `audio_tx_fifo_regs`

## Requirements
- R1: The bus selects a 32-bit register by word index (byte offset / 4). The registers are:
  - word 0: identity value;
  - word 1: setup;
  - word 2: cause mask, in bits 1:0;
  - word 3: cause flags, in bits 1:0;
  - words 4 to 7: sample entry, which reads as zero.
  While `bus_rd` is high, `bus_rdata` shows the selected register at once. Otherwise `bus_rdata` is zero.
- R2: The identity register always reads the parameter `VERSION`. A write to it has no effect.
- R3: A write to any of words 4 to 7 appends `bus_wdata` to the queue. `pop_valid` is high while the queue holds data, and `pop_data` shows the oldest word. A `pop_req` while `pop_valid` is high removes that word. A pop and a push in the same cycle both take effect.
- R4: The queue holds 2^`DEPTH_LOG2` words. A push that arrives while the queue is full is dropped, and the stored words are unchanged.
- R5: The setup register has these fields:
  - bit 0: transmit enable;
  - bit 1: interrupt enable;
  - bits 15:8: clock ratio;
  - bits 21:16: sample resolution;
  - bits 27:24: level code;
  - bits 31:28: channel field.
  All other bits store nothing and read zero. Each field drives its own output port.
- R6: The low-water mark is (depth/2) >> (code − 1). Code 0 acts as code 1. Flag bit 1 (level) is set on any clock edge at which the fill before that edge is below the mark.
- R7: Flag bit 0 (underrun) is set on any clock edge at which the queue is empty before that edge.
- R8: The flags are sticky. Writing 1 to a flag bit clears it, unless its condition holds at the same edge, in which case it stays set. Writing 0 has no effect.
- R9: `irq` = setup bit 1 AND (flag bit 0 AND mask bit 0, OR flag bit 1 AND mask bit 1).
- R10: Reset clears the setup register, the mask and the flags, and empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_word | input | 3 | Register word index |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | Interrupt request |
| pop_req | input | 1 | Serializer takes the head word |
| pop_valid | output | 1 | Queue not empty |
| pop_data | output | 32 | Head word of the queue |
| cfg_tx_en | output | 1 | Transmit enable field |
| cfg_ratio | output | 8 | Clock ratio field |
| cfg_res | output | 6 | Sample resolution field |
| cfg_level | output | 4 | Level code field |
| cfg_chan | output | 4 | Channel field |

## Verification
The bench builds the block with `DEPTH_LOG2` = 4, a 16-word queue. This small depth makes both the full queue and every low-water mark reachable in a few dozen cycles. With that depth, level codes 1 to 4 give marks of 8, 4, 2 and 1. Code 5 shifts the mark to 0, so the level cause can never fire, and the bench covers that case too. A behavioural queue model tracks the flags, mask and setup, and is compared with the interrupt, pop port, setup outputs and read data on every cycle.

// File: rtl/audio_tx_fifo_regs.sv
module audio_tx_fifo_regs #(
  parameter int          DEPTH_LOG2 = 10,
  parameter logic [31:0] VERSION    = 32'h0001_0200
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_word,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        pop_req,
  output logic        pop_valid,
  output logic [31:0] pop_data,
  output logic        cfg_tx_en,
  output logic [7:0]  cfg_ratio,
  output logic [5:0]  cfg_res,
  output logic [3:0]  cfg_level,
  output logic [3:0]  cfg_chan
);
  localparam int              DEPTH    = 1 << DEPTH_LOG2;
  localparam int              CW       = DEPTH_LOG2 + 1;
  localparam logic [CW-1:0]   HALF     = CW'(DEPTH / 2);
  localparam logic [CW-1:0]   FULL     = CW'(DEPTH);
  localparam logic [31:0]     CFG_BITS = 32'hFF3F_FF03;

  logic [31:0]           mem [DEPTH];
  logic [DEPTH_LOG2-1:0] wp, rp;
  logic [CW-1:0]         count;
  logic [31:0]           cfg;
  logic [1:0]            mask, status;

  wire          sel_data = bus_word[2];
  wire          push     = bus_wr & sel_data & (count != FULL);
  wire          pop      = pop_req & (count != '0);
  wire [3:0]    shift    = (cfg[27:24] == 4'd0) ? 4'd0 : cfg[27:24] - 4'd1;
  wire [CW-1:0] trig     = HALF >> shift;
  wire [1:0]    cond     = {count < trig, count == '0};
  wire [1:0]    clr      = (bus_wr && bus_word == 3'd3) ? bus_wdata[1:0] : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg    <= '0;
      mask   <= '0;
      status <= '0;
    end else begin
      if (bus_wr && bus_word == 3'd1) cfg  <= bus_wdata & CFG_BITS;
      if (bus_wr && bus_word == 3'd2) mask <= bus_wdata[1:0];
      status <= (status & ~clr) | cond;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= bus_wdata;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_word)
        3'd0:    bus_rdata = VERSION;
        3'd1:    bus_rdata = cfg;
        3'd2:    bus_rdata = {30'd0, mask};
        3'd3:    bus_rdata = {30'd0, status};
        default: bus_rdata = '0;
      endcase
    end
  end

  assign irq       = cfg[1] & |(status & mask);
  assign pop_valid = count != '0;
  assign pop_data  = mem[rp];
  assign cfg_tx_en = cfg[0];
  assign cfg_ratio = cfg[15:8];
  assign cfg_res   = cfg[21:16];
  assign cfg_level = cfg[27:24];
  assign cfg_chan  = cfg[31:28];
endmodule

// File: rtl/audio_tx_fifo_chk.sv
module audio_tx_fifo_chk #(
  parameter int DEPTH_LOG2 = 10
) (
  input logic                clk,
  input logic                rst_n,
  input logic [DEPTH_LOG2:0] count,
  input logic [DEPTH_LOG2:0] trig,
  input logic [1:0]          status,
  input logic                int_en,
  input logic                irq
);
  localparam int CW = DEPTH_LOG2 + 1;

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> int_en);

  a_r7_empty_sets_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |=> status[0]);

  a_r6_low_sets_level: assert property (@(posedge clk) disable iff (!rst_n)
    (count < trig) |=> status[1]);

  a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(1 << DEPTH_LOG2));

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count) || count == $past(count) + 1'b1 ||
              count + 1'b1 == $past(count)));
endmodule

bind audio_tx_fifo_regs audio_tx_fifo_chk #(.DEPTH_LOG2(DEPTH_LOG2)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .count  (count),
  .trig   (trig),
  .status (status),
  .int_en (cfg[1]),
  .irq    (irq)
);

// File: tb/tb_audio_tx_fifo_regs.sv
module tb_audio_tx_fifo_regs;
  localparam int          CLK_PERIOD = 10;
  localparam int          DL2        = 4;
  localparam int          DEPTH      = 1 << DL2;
  localparam logic [31:0] VER        = 32'hA5C3_0017;

  logic        clk = 0, rst_n = 0;
  logic [2:0]  bus_word = 0;
  logic        bus_wr = 0, bus_rd = 0, pop_req = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata, pop_data;
  logic        irq, pop_valid, cfg_tx_en;
  logic [7:0]  cfg_ratio;
  logic [5:0]  cfg_res;
  logic [3:0]  cfg_level, cfg_chan;

  audio_tx_fifo_regs #(.DEPTH_LOG2(DL2), .VERSION(VER)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] q[$];
  logic [31:0] m_cfg = 0;
  logic [1:0]  m_mask = 0, m_stat = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int m_trig(logic [3:0] code);
    int s = (code == 0) ? 0 : code - 1;
    return (DEPTH / 2) >> s;
  endfunction

  function automatic logic [31:0] m_read(logic [2:0] w);
    case (w)
      3'd0: return VER;
      3'd1: return m_cfg;
      3'd2: return {30'd0, m_mask};
      3'd3: return {30'd0, m_stat};
      default: return 32'd0;
    endcase
  endfunction

  task automatic compare_all(logic rd, logic [2:0] w);
    chk("R9 irq", {31'd0, irq}, {31'd0, m_cfg[1] & |(m_stat & m_mask)});
    chk("R3 pop_valid", {31'd0, pop_valid}, {31'd0, q.size() != 0});
    if (q.size() != 0) chk("R3 pop_data", pop_data, q[0]);
    chk("R5 cfg outputs", {cfg_chan, cfg_level, 2'b00, cfg_res, cfg_ratio, 7'd0, cfg_tx_en},
        m_cfg & 32'hFF3F_FF01);
    chk("R1 rdata", bus_rdata, rd ? m_read(w) : 32'd0);
  endtask

  task automatic cyc(logic wr, logic rd, logic [2:0] w, logic [31:0] d, logic pp,
                     string tag = "", bit use_exp = 0, logic [31:0] exp = 0);
    int pre;
    logic [1:0] clr;
    bus_wr = wr; bus_rd = rd; bus_word = w; bus_wdata = d; pop_req = pp;
    #1;
    compare_all(rd, w);
    if (use_exp) chk(tag, bus_rdata, exp);
    @(posedge clk);
    pre = q.size();
    clr = (wr && w == 3'd3) ? d[1:0] : 2'b00;
    m_stat = (m_stat & ~clr) | {pre < m_trig(m_cfg[27:24]), pre == 0};
    if (wr && w == 3'd1) m_cfg = d & 32'hFF3F_FF03;
    if (wr && w == 3'd2) m_mask = d[1:0];
    if (pp && pre > 0) void'(q.pop_front());
    if (wr && w[2] && pre < DEPTH) q.push_back(d);
    @(negedge clk);
  endtask

  task automatic wr_reg(logic [2:0] w, logic [31:0] d); cyc(1, 0, w, d, 0); endtask
  task automatic rd_exp(logic [2:0] w, string tag, logic [31:0] exp); cyc(0, 1, w, 0, 0, tag, 1, exp); endtask
  task automatic idle(); cyc(0, 0, 0, 0, 0); endtask
  task automatic push(logic [31:0] d, logic [2:0] w = 3'd4); cyc(1, 0, w, d, 0); endtask
  task automatic pop(); cyc(0, 0, 0, 0, 1); endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // reset state
    rd_exp(3'd1, "R10 cfg after reset", 32'd0);
    rd_exp(3'd2, "R10 mask after reset", 32'd0);
    chk("R10 queue empty after reset", {31'd0, pop_valid}, 32'd0);
    rd_exp(3'd3, "R7 flags while empty", 32'd3);
    // identity register
    rd_exp(3'd0, "R2 identity", VER);
    wr_reg(3'd0, 32'h1234_5678);
    rd_exp(3'd0, "R2 identity after write", VER);
    // setup register fields
    wr_reg(3'd1, 32'hFFFF_FFFF);
    rd_exp(3'd1, "R5 setup readback", 32'hFF3F_FF03);
    wr_reg(3'd1, 32'h5A15_3C01);
    rd_exp(3'd1, "R5 setup readback 2", 32'h5A15_3C01);
    rd_exp(3'd5, "R1 sample entry reads zero", 32'd0);
    // interrupt gating
    wr_reg(3'd2, 32'h1);
    wr_reg(3'd1, 32'h0100_0002);
    chk("R9 irq with enable and underrun", {31'd0, irq}, 32'd1);
    wr_reg(3'd3, 32'h3);
    rd_exp(3'd3, "R8 clear while conditions hold", 32'd3);
    wr_reg(3'd1, 32'h0100_0000);
    chk("R9 irq masked by global enable", {31'd0, irq}, 32'd0);
    wr_reg(3'd1, 32'h0100_0002);
    // basic order, all four entry words
    push(32'h1111_0000, 3'd4); push(32'h2222_0000, 3'd5);
    push(32'h3333_0000, 3'd6); push(32'h4444_0000, 3'd7);
    chk("R3 head word", pop_data, 32'h1111_0000);
    pop(); pop();
    cyc(1, 0, 3'd4, 32'h5555_0000, 1);
    pop(); pop(); pop();
    chk("R3 empty after draining", {31'd0, pop_valid}, 32'd0);
    pop();
    // fill to full and overflow
    for (int i = 0; i < DEPTH + 3; i++) push(32'hC000_0000 + i);
    chk("R4 head kept on overflow", pop_data, 32'hC000_0000);
    cyc(1, 0, 3'd4, 32'hDEAD_BEEF, 1);
    for (int i = 0; i < DEPTH; i++) pop();
    chk("R4 queue drained after depth pops", {31'd0, pop_valid}, 32'd0);
    // level marks
    for (int code = 0; code < 6; code++) begin
      wr_reg(3'd1, {4'd0, 4'(code), 22'd0, 2'b10});
      wr_reg(3'd2, 32'h2);
      for (int n = 0; n <= DEPTH / 2 + 1; n++) begin
        wr_reg(3'd3, 32'h3);
        idle();
        if (code == 2 && n == 3) rd_exp(3'd3, "R6 below mark of 4", 32'd2);
        else if (code == 2 && n == 4) rd_exp(3'd3, "R6 at mark of 4", 32'd0);
        else cyc(0, 1, 3'd3, 0, 0);
        push(32'hB000_0000 + n);
      end
      while (q.size() != 0) pop();
    end
    // sticky flag and mask behaviour
    wr_reg(3'd1, 32'h0100_0002);
    wr_reg(3'd2, 32'h1);
    push(32'h7);
    wr_reg(3'd3, 32'h1);
    idle();
    rd_exp(3'd3, "R8 underrun cleared when not empty", 32'd2);
    chk("R9 irq low with underrun cleared, level masked", {31'd0, irq}, 32'd0);
    pop(); idle();
    rd_exp(3'd3, "R8 underrun sticky", 32'd3);
    wr_reg(3'd3, 32'h0);
    rd_exp(3'd3, "R8 writing zero keeps flags", 32'd3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule